// File: doc/BRIEF.md
# Multi-Port Shared Memory with Write Arbitration

This block is a word-addressed memory shared by several processor ports. Each port has its own request, write enable, address, write data and read data, so every port can reach the array in the same cycle. When two or more ports write the same word in one cycle, a fixed priority by port index picks the single write that lands. Each port that loses is told so one cycle later and has to retry.

A small configuration table of address windows can make a range of words private to a chosen set of ports. A port outside that set is turned away: it gets zero data and an error pulse, and the memory is left as it was. Every write that lands is announced one cycle later on a notice channel for that writer. The notice carries the word address, the writer's index and a destination mask that leaves out the writer, so that write-through caches on the other ports can update or drop their copies.

All results are registered. Read data, conflict and refusal flags and notices for the requests of cycle t appear in cycle t+1 and last one cycle.

Top module: `mpm_shared_mem`

## Requirements
- R1: Requests on all ports in one cycle to distinct addresses all complete. Read data for an accepted request appears on that port's `rdata` one cycle later, and `rdata` is zero for a port that made no request.
- R2: A read (or a write) of a word that another port writes in the same cycle returns the word's value from before that cycle's write.
- R3: At most one write lands in a given word per cycle. After a same-address collision, the word holds exactly the winner's data.
- R4: Among accepted writes to one address in one cycle, the lowest port index wins. Every other writer sees `conflict` high for exactly the next cycle, and its data is dropped. Port 0 never sees a conflict.
- R5: A refused request returns zero on `rdata`, raises `refused` for the next cycle, writes nothing, produces no notice and never raises `conflict`.
- R6: The window table has 4 entries, each holding an enable, an inclusive base, an inclusive limit and a port mask (bit p set = port p allowed). The lowest-index enabled entry that covers an address decides access. An address covered by no enabled entry is open to every port. An entry is written through `cfg_we`/`cfg_idx` and governs requests from the next cycle on.
- R7: Each write that lands produces, in the next cycle only, `upd_valid[w]` for writer w, with `upd_addr` set to the word address, `upd_src` set to w, and `upd_dest` set to every port except w.
- R8: Reset (synchronous, active high) clears every memory word, disables every window entry and drives all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NP | Per-port access request |
| wen | input | NP | Per-port write enable (read when low) |
| addr | input | NP*AW | Per-port word address, port p at bits p*AW |
| wdata | input | NP*DW | Per-port write data, port p at bits p*DW |
| rdata | output | NP*DW | Per-port registered read data (old contents) |
| conflict | output | NP | Per-port one-cycle pulse: write lost to a lower index |
| refused | output | NP | Per-port one-cycle pulse: access blocked by a window |
| cfg_we | input | 1 | Window table write strobe |
| cfg_idx | input | 2 | Window entry to write |
| cfg_en | input | 1 | Enable of the written entry |
| cfg_base | input | AW | Inclusive lower address of the window |
| cfg_limit | input | AW | Inclusive upper address of the window |
| cfg_mask | input | NP | Ports allowed inside the window |
| upd_valid | output | NP | Per-writer notice valid |
| upd_addr | output | NP*AW | Per-writer notice word address |
| upd_src | output | NP*2 | Per-writer notice writer index |
| upd_dest | output | NP*NP | Per-writer notice destination mask |

## Verification
The assertions assume that `req`, `wen` and `addr` are known and stable around each rising edge. They also assume that reset is held for at least one edge before any request, because the notice check compares against the request of the previous cycle. The bench drives every input on the falling edge from a seeded random source and keeps addresses in a small window so that same-word collisions and window hits are frequent. Table writes are mixed in at random and in directed steps, and the window bounds stay inside the address space.

// File: rtl/mpm_pkg.sv
package mpm_pkg;
    localparam int MPM_PORTS   = 4;
    localparam int MPM_ADDR_W  = 6;
    localparam int MPM_DATA_W  = 16;
    localparam int MPM_WINDOWS = 4;

    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_OK   = 2'd1,
        ACC_DENY = 2'd2
    } acc_e;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/mpm_window_guard.sv
module mpm_window_guard
    import mpm_pkg::*;
#(
    parameter int NP   = MPM_PORTS,
    parameter int AW   = MPM_ADDR_W,
    parameter int NREG = MPM_WINDOWS,
    localparam int RIW = idx_w(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [RIW-1:0]   cfg_idx,
    input  logic             cfg_en,
    input  logic [AW-1:0]    cfg_base,
    input  logic [AW-1:0]    cfg_limit,
    input  logic [NP-1:0]    cfg_mask,
    input  logic [NP-1:0]    req,
    input  logic [NP*AW-1:0] addr,
    output acc_e             verdict [NP]
);
    logic          win_en    [NREG];
    logic [AW-1:0] win_base  [NREG];
    logic [AW-1:0] win_limit [NREG];
    logic [NP-1:0] win_mask  [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                win_en[i]    <= 1'b0;
                win_base[i]  <= '0;
                win_limit[i] <= '0;
                win_mask[i]  <= '0;
            end
        end else if (cfg_we) begin
            win_en[cfg_idx]    <= cfg_en;
            win_base[cfg_idx]  <= cfg_base;
            win_limit[cfg_idx] <= cfg_limit;
            win_mask[cfg_idx]  <= cfg_mask;
        end
    end

    for (genvar p = 0; p < NP; p++) begin : g_port
        logic [AW-1:0] a;
        logic          allow;
        logic          decided;
        assign a = addr[p*AW +: AW];

        always_comb begin
            allow   = 1'b1;
            decided = 1'b0;
            for (int i = 0; i < NREG; i++) begin
                if (!decided && win_en[i] && a >= win_base[i] && a <= win_limit[i]) begin
                    decided = 1'b1;
                    allow   = win_mask[i][p];
                end
            end
            if (!req[p])    verdict[p] = ACC_IDLE;
            else if (allow) verdict[p] = ACC_OK;
            else            verdict[p] = ACC_DENY;
        end

        AST_IDLE_PORT_NOT_JUDGED: assert property (@(posedge clk) disable iff (rst)
            !req[p] |-> verdict[p] == ACC_IDLE); // R5
    end
endmodule

// File: rtl/mpm_write_arbiter.sv
module mpm_write_arbiter
    import mpm_pkg::*;
#(
    parameter int NP = MPM_PORTS,
    parameter int AW = MPM_ADDR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NP-1:0]    wr_try,
    input  logic [NP*AW-1:0] addr,
    output logic [NP-1:0]    win,
    output logic [NP-1:0]    lose
);
    for (genvar p = 0; p < NP; p++) begin : g_port
        logic beaten;
        always_comb begin
            beaten = 1'b0;
            for (int q = 0; q < p; q++) begin
                if (wr_try[q] && addr[q*AW +: AW] == addr[p*AW +: AW])
                    beaten = 1'b1;
            end
        end
        assign win[p]  = wr_try[p] && !beaten;
        assign lose[p] = wr_try[p] && beaten;

        for (genvar q = p + 1; q < NP; q++) begin : g_pair
            AST_ONE_WRITE_PER_WORD: assert property (@(posedge clk) disable iff (rst)
                (win[p] && win[q]) |-> addr[p*AW +: AW] != addr[q*AW +: AW]); // R3
        end
    end

    AST_TOP_PRIORITY_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_try[0] |-> win[0]); // R4
endmodule

// File: rtl/mpm_store.sv
module mpm_store
    import mpm_pkg::*;
#(
    parameter int NP = MPM_PORTS,
    parameter int AW = MPM_ADDR_W,
    parameter int DW = MPM_DATA_W,
    localparam int DEPTH = 1 << AW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NP-1:0]    rd_en,
    input  logic [NP-1:0]    win,
    input  logic [NP*AW-1:0] addr,
    input  logic [NP*DW-1:0] wdata,
    output logic [NP*DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
            rdata <= '0;
        end else begin
            for (int p = 0; p < NP; p++) begin
                rdata[p*DW +: DW] <= rd_en[p] ? mem[addr[p*AW +: AW]] : '0;
                if (win[p]) mem[addr[p*AW +: AW]] <= wdata[p*DW +: DW];
            end
        end
    end
endmodule

// File: rtl/mpm_shared_mem.sv
module mpm_shared_mem
    import mpm_pkg::*;
#(
    parameter int NP   = MPM_PORTS,
    parameter int AW   = MPM_ADDR_W,
    parameter int DW   = MPM_DATA_W,
    parameter int NREG = MPM_WINDOWS,
    localparam int RIW = idx_w(NREG),
    localparam int PW  = idx_w(NP)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NP-1:0]    req,
    input  logic [NP-1:0]    wen,
    input  logic [NP*AW-1:0] addr,
    input  logic [NP*DW-1:0] wdata,
    output logic [NP*DW-1:0] rdata,
    output logic [NP-1:0]    conflict,
    output logic [NP-1:0]    refused,
    input  logic             cfg_we,
    input  logic [RIW-1:0]   cfg_idx,
    input  logic             cfg_en,
    input  logic [AW-1:0]    cfg_base,
    input  logic [AW-1:0]    cfg_limit,
    input  logic [NP-1:0]    cfg_mask,
    output logic [NP-1:0]    upd_valid,
    output logic [NP*AW-1:0] upd_addr,
    output logic [NP*PW-1:0] upd_src,
    output logic [NP*NP-1:0] upd_dest
);
    acc_e          verdict [NP];
    logic [NP-1:0] granted;
    logic [NP-1:0] denied;
    logic [NP-1:0] wr_try;
    logic [NP-1:0] win;
    logic [NP-1:0] lose;

    mpm_window_guard #(.NP(NP), .AW(AW), .NREG(NREG)) i_guard (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
        .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_mask(cfg_mask),
        .req(req), .addr(addr), .verdict(verdict)
    );

    for (genvar p = 0; p < NP; p++) begin : g_dec
        assign granted[p] = (verdict[p] == ACC_OK);
        assign denied[p]  = (verdict[p] == ACC_DENY);
    end
    assign wr_try = granted & wen;

    mpm_write_arbiter #(.NP(NP), .AW(AW)) i_arb (
        .clk(clk), .rst(rst), .wr_try(wr_try), .addr(addr),
        .win(win), .lose(lose)
    );

    mpm_store #(.NP(NP), .AW(AW), .DW(DW)) i_store (
        .clk(clk), .rst(rst), .rd_en(granted), .win(win),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            conflict  <= '0;
            refused   <= '0;
            upd_valid <= '0;
        end else begin
            conflict  <= lose;
            refused   <= denied;
            upd_valid <= win;
        end
    end

    for (genvar w = 0; w < NP; w++) begin : g_note
        always_ff @(posedge clk) begin
            if (rst || !win[w]) begin
                upd_addr[w*AW +: AW] <= '0;
                upd_src[w*PW +: PW]  <= '0;
                upd_dest[w*NP +: NP] <= '0;
            end else begin
                upd_addr[w*AW +: AW] <= addr[w*AW +: AW];
                upd_src[w*PW +: PW]  <= PW'(w);
                upd_dest[w*NP +: NP] <= ~(NP'(1) << w);
            end
        end

        AST_NOTICE_SKIPS_WRITER: assert property (@(posedge clk) disable iff (rst)
            upd_valid[w] |-> !upd_dest[w*NP + w]); // R7
        AST_NOTICE_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
            upd_valid[w] |-> ($past(req[w] && wen[w]) &&
                              upd_addr[w*AW +: AW] == $past(addr[w*AW +: AW]))); // R7
        AST_REFUSED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
            refused[w] |-> rdata[w*DW +: DW] == '0); // R5
        AST_REFUSED_NOT_CONFLICT: assert property (@(posedge clk) disable iff (rst)
            !(refused[w] && (conflict[w] || upd_valid[w]))); // R5
    end

    AST_PORT0_NEVER_LOSES: assert property (@(posedge clk) disable iff (rst)
        !conflict[0]); // R4
endmodule

// File: tb/test_mpm_shared_mem.sv
`timescale 1ns/1ps
module test_mpm_shared_mem;
    import mpm_pkg::*;
    localparam int NP = MPM_PORTS;
    localparam int AW = MPM_ADDR_W;
    localparam int DW = MPM_DATA_W;
    localparam int NR = MPM_WINDOWS;
    localparam int PW = idx_w(NP);
    localparam int RIW = idx_w(NR);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [NP-1:0]    req = '0, wen = '0;
    logic [NP*AW-1:0] addr = '0;
    logic [NP*DW-1:0] wdata = '0;
    logic [NP*DW-1:0] rdata;
    logic [NP-1:0]    conflict, refused, upd_valid;
    logic             cfg_we = 1'b0, cfg_en = 1'b0;
    logic [RIW-1:0]   cfg_idx = '0;
    logic [AW-1:0]    cfg_base = '0, cfg_limit = '0;
    logic [NP-1:0]    cfg_mask = '0;
    logic [NP*AW-1:0] upd_addr;
    logic [NP*PW-1:0] upd_src;
    logic [NP*NP-1:0] upd_dest;

    mpm_shared_mem i_mpm_shared_mem (
        .clk(clk), .rst(rst), .req(req), .wen(wen), .addr(addr), .wdata(wdata),
        .rdata(rdata), .conflict(conflict), .refused(refused),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_base(cfg_base),
        .cfg_limit(cfg_limit), .cfg_mask(cfg_mask), .upd_valid(upd_valid),
        .upd_addr(upd_addr), .upd_src(upd_src), .upd_dest(upd_dest)
    );

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    // reference state
    logic [DW-1:0] m_mem [1 << AW];
    logic          m_en [NR];
    logic [AW-1:0] m_lo [NR], m_hi [NR];
    logic [NP-1:0] m_msk [NR];
    logic [DW-1:0] e_rd [NP];
    logic [NP-1:0] e_cf, e_rf, e_uv;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit m_allow(input int p, input logic [AW-1:0] a);
        for (int i = 0; i < NR; i++)
            if (m_en[i] && a >= m_lo[i] && a <= m_hi[i]) return m_msk[i][p];
        return 1'b1;
    endfunction

    function automatic logic [AW-1:0] pa(input int p);
        return addr[p*AW +: AW];
    endfunction

    // Predict outputs of current inputs, update model, pass one edge, compare.
    task automatic cycle();
        logic [NP-1:0] ok;
        logic [AW-1:0] ua [NP];
        for (int p = 0; p < NP; p++) begin
            ok[p]   = req[p] && m_allow(p, pa(p));
            e_rf[p] = req[p] && !ok[p];
            e_rd[p] = ok[p] ? m_mem[pa(p)] : '0;
            ua[p]   = pa(p);
        end
        for (int p = 0; p < NP; p++) begin
            bit lost = 1'b0;
            for (int q = 0; q < p; q++)
                if (ok[q] && wen[q] && pa(q) == pa(p)) lost = 1'b1;
            e_cf[p] = ok[p] && wen[p] && lost;
            e_uv[p] = ok[p] && wen[p] && !lost;
        end
        for (int p = 0; p < NP; p++)
            if (e_uv[p]) m_mem[pa(p)] = wdata[p*DW +: DW];
        if (cfg_we) begin
            m_en[cfg_idx] = cfg_en; m_lo[cfg_idx] = cfg_base;
            m_hi[cfg_idx] = cfg_limit; m_msk[cfg_idx] = cfg_mask;
        end
        @(negedge clk);
        cycles++;
        for (int p = 0; p < NP; p++) begin
            chk(rdata[p*DW +: DW] == e_rd[p], e_rf[p] ? "R5 refused rdata" : "R1 R2 rdata",
                32'(rdata[p*DW +: DW]), 32'(e_rd[p]));
            chk(conflict[p] == e_cf[p], "R4 conflict flag", 32'(conflict[p]), 32'(e_cf[p]));
            chk(refused[p] == e_rf[p], "R5 R6 refused flag", 32'(refused[p]), 32'(e_rf[p]));
            chk(upd_valid[p] == e_uv[p], "R7 notice valid", 32'(upd_valid[p]), 32'(e_uv[p]));
            if (e_uv[p]) begin
                chk(upd_addr[p*AW +: AW] == ua[p], "R7 notice addr", 32'(upd_addr[p*AW +: AW]), 32'(ua[p]));
                chk(upd_src[p*PW +: PW] == PW'(p), "R7 notice src", 32'(upd_src[p*PW +: PW]), 32'(p));
                chk(upd_dest[p*NP +: NP] == ~(NP'(1) << p), "R7 notice dest",
                    32'(upd_dest[p*NP +: NP]), 32'(~(NP'(1) << p)));
            end
        end
    endtask

    task automatic idle();
        req = '0; wen = '0; cfg_we = 1'b0;
    endtask

    task automatic port(input int p, input bit w, input int a, input logic [DW-1:0] d);
        req[p] = 1'b1; wen[p] = w; addr[p*AW +: AW] = AW'(a); wdata[p*DW +: DW] = d;
    endtask

    task automatic set_win(input int i, input bit en, input int lo, input int hi, input logic [NP-1:0] m);
        cfg_we = 1'b1; cfg_idx = RIW'(i); cfg_en = en;
        cfg_base = AW'(lo); cfg_limit = AW'(hi); cfg_mask = m;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        for (int w = 0; w < (1 << AW); w++) m_mem[w] = '0;
        for (int i = 0; i < NR; i++) begin
            m_en[i] = 1'b0; m_lo[i] = '0; m_hi[i] = '0; m_msk[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8: outputs zero after reset
        chk(rdata == '0, "R8 rdata after reset", 32'(rdata[DW-1:0]), 0);
        chk({conflict, refused, upd_valid} == '0, "R8 flags after reset",
            32'({conflict, refused, upd_valid}), 0);
        // R8: memory reads zero, R1: all ports in one cycle
        idle(); for (int p = 0; p < NP; p++) port(p, 0, p * 7, '0);
        cycle();
        chk(rdata == '0, "R8 memory cleared", 32'(rdata[DW-1:0]), 0);

        // R1: all ports write distinct words, then read back
        idle(); for (int p = 0; p < NP; p++) port(p, 1, 40 + p, DW'(16'h1000 + p));
        cycle();
        idle(); for (int p = 0; p < NP; p++) port(p, 0, 40 + NP - 1 - p, '0);
        cycle();
        chk(rdata[0 +: DW] == DW'(16'h1000 + NP - 1), "R1 cross read", 32'(rdata[0 +: DW]),
            32'(16'h1000 + NP - 1));

        // R3 R4: all ports write word 5
        idle(); for (int p = 0; p < NP; p++) port(p, 1, 5, DW'(16'hA0 + p));
        cycle();
        chk(conflict == {{(NP-1){1'b1}}, 1'b0}, "R4 losers flagged", 32'(conflict),
            32'({{(NP-1){1'b1}}, 1'b0}));
        idle(); cycle();
        chk(conflict == '0, "R4 conflict lasts one cycle", 32'(conflict), 0);
        idle(); port(NP - 1, 0, 5, '0); cycle();
        chk(rdata[(NP-1)*DW +: DW] == DW'(16'hA0), "R3 winner data kept",
            32'(rdata[(NP-1)*DW +: DW]), 32'h00A0);

        // R4: ports 1..NP-1 collide, port 1 wins
        idle(); for (int p = 1; p < NP; p++) port(p, 1, 6, DW'(16'hB0 + p));
        cycle();
        chk(upd_valid[1] && !conflict[1], "R4 port1 wins without port0", 32'(upd_valid), 32'h2);

        // R2: write and read same word in one cycle
        idle(); port(0, 1, 9, 16'hAAAA); port(2, 0, 9, '0); cycle();
        chk(rdata[2*DW +: DW] == '0, "R2 old data returned", 32'(rdata[2*DW +: DW]), 0);
        idle(); port(2, 0, 9, '0); cycle();
        chk(rdata[2*DW +: DW] == 16'hAAAA, "R2 new data next cycle", 32'(rdata[2*DW +: DW]), 32'hAAAA);

        // R6: window 0 private to port 1, window 1 overlapping, open to all
        idle(); set_win(0, 1, 16, 23, NP'(4'b0010)); cycle();
        idle(); set_win(1, 1, 20, 30, '1); cycle();
        idle(); port(0, 1, 20, 16'h5555); port(1, 0, 20, '0); cycle();
        chk(refused[0] && !refused[1], "R6 lowest window decides", 32'(refused), 32'h1);
        chk(upd_valid[0] == 1'b0, "R5 no notice on refusal", 32'(upd_valid[0]), 0);
        idle(); port(1, 0, 20, '0); port(0, 0, 25, '0); cycle();
        chk(rdata[DW +: DW] == '0, "R5 refused write left memory", 32'(rdata[DW +: DW]), 0);
        chk(refused == '0, "R6 overlap above window 0 open", 32'(refused), 0);
        idle(); port(3, 0, 50, '0); cycle();
        chk(refused[3] == 1'b0, "R6 uncovered address shared", 32'(refused[3]), 0);
        // R6: disable window 0
        idle(); set_win(0, 0, 16, 23, '0); port(0, 0, 17, '0); cycle();
        chk(refused[0] == 1'b1, "R6 config applies next cycle", 32'(refused[0]), 1);
        idle(); port(0, 0, 17, '0); cycle();
        chk(refused[0] == 1'b0, "R6 disabled window ignored", 32'(refused[0]), 0);

        // random phase
        for (int n = 0; n < 3000; n++) begin
            idle();
            for (int p = 0; p < NP; p++) begin
                if ($urandom_range(3) != 0) begin
                    int a = ($urandom_range(3) == 0) ? int'($urandom_range((1 << AW) - 1))
                                                     : int'($urandom_range(15));
                    port(p, $urandom_range(1), a, DW'($urandom));
                end
            end
            if ($urandom_range(19) == 0) begin
                int lo = $urandom_range(15);
                set_win($urandom_range(NR - 1), $urandom_range(1), lo,
                        lo + int'($urandom_range(6)), NP'($urandom));
            end
            cycle();
        end
        idle(); cycle();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule